// File: doc/BRIEF.md
# Block Transfer Sequencer

This block streams the data phase of a card transaction between a byte-wide card data port and a 16-bit word FIFO. Software programs a block length in bytes and a number of blocks, then issues a start pulse with a direction. In the receive direction, pairs of bytes arriving from the card are packed into words and pushed into the FIFO. In the transmit direction, words taken from the head of the FIFO are split back into bytes for the card.

Each block is counted down byte by byte. When a block ends, the byte counter reloads and the block counter steps down. When the last block ends, both counters reload, the sequencer goes idle and a sticky done flag is raised. Receive flow stops while the FIFO holds more words than an almost-full threshold, and transmit flow stops while the FIFO is empty. The FIFO storage itself lives outside this block.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset `busy` and `xfer_done` are 0 and both live counters read 1. A write to `len_field` or `cnt_field` programs that field value plus one, and that value shows on the matching live counter.
- R2: A block-count write reloads the block counter to the new count and the byte counter to the programmed block length, even in the middle of a transfer.
- R3: On receive, the first byte of each pair lands in word bits 7:0 and the second in bits 15:8. A block of odd length ends with a word whose bits 15:8 are zero.
- R4: Receive accepts no byte while `fifo_level` exceeds `af_level`. Transmit offers no byte while `fifo_level` is 0. Both resume once the condition clears.
- R5: On transmit, each word is sent as bits 7:0 then bits 15:8. The final word of an odd-length block sends only bits 7:0 and is then popped.
- R6: When the last byte of a block moves, the byte counter reloads the programmed length and the block counter decrements.
- R7: When the last byte of the last block moves, both counters reload their programmed values, `busy` falls, `xfer_done` is set, and no further byte is accepted.
- R8: `len_live` and `cnt_live` show the remaining byte and block counts during a transfer, not the programmed values.
- R9: While `ctrl_en` is 0, `busy` clears on the next cycle without setting `xfer_done`, and a start pulse is ignored.
- R10: A start pulse clears `xfer_done` and sets `busy`. The direction is receive when `start_rx` is 1 and transmit when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low aborts a transfer |
| len_we | input | 1 | Block-length write strobe |
| len_field | input | 11 | Block length minus one |
| cnt_we | input | 1 | Block-count write strobe |
| cnt_field | input | 11 | Block count minus one |
| len_live | output | 12 | Bytes remaining in the current block |
| cnt_live | output | 12 | Blocks remaining in the transfer |
| start | input | 1 | Start pulse |
| start_rx | input | 1 | Direction with start: 1 receive, 0 transmit |
| busy | output | 1 | Transfer active |
| xfer_done | output | 1 | Sticky done flag |
| fifo_level | input | 6 | FIFO occupancy in words |
| af_level | input | 5 | Almost-full threshold |
| fifo_wr_valid | output | 1 | Push a word into the FIFO |
| fifo_wr_word | output | 16 | Word pushed |
| fifo_rd_pop | output | 1 | Pop the FIFO head |
| fifo_rd_word | input | 16 | FIFO head word |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Sequencer accepts the byte |
| card_rx_data | input | 8 | Byte from the card |
| card_tx_valid | output | 1 | Sequencer offers a byte |
| card_tx_ready | input | 1 | Card accepts the byte |
| card_tx_data | output | 8 | Byte to the card |

## Verification
Receive runs use an odd block length over several blocks, so that pair packing can be told apart from the zero-padded tail word. A long even block is run against a low threshold with draining held off, which separates correct stalling from overrun. Transmit runs put a marker byte in the unused upper half of odd-block words, to show it is never sent. A run with a stuttering card ready separates handshake-gated stepping from free-running counting. Partial transfers, stopped by limiting the bytes the card offers, expose the live counters, the mid-transfer count rewrite and the abort path.

// File: rtl/blk_xfer_pkg.sv
// Package: shared widths for the block transfer sequencer.
// Assumes a word holds exactly two card bytes.
package blk_xfer_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int FIELD_W = 11;
    localparam int CNT_W   = FIELD_W + 1;
endpackage

// File: rtl/xfer_len_blk_ctr.sv
// Byte-per-block and block-per-transfer counters with programmed reload values.
// Assumes at most one byte step per cycle; configuration writes take priority over a step.
module xfer_len_blk_ctr #(
    parameter int FIELD_W = 11,
    parameter int CNT_W   = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               len_we,
    input  logic [FIELD_W-1:0] len_field,
    input  logic               cnt_we,
    input  logic [FIELD_W-1:0] cnt_field,
    input  logic               step,
    output logic [CNT_W-1:0]   len_live,
    output logic [CNT_W-1:0]   cnt_live,
    output logic               blk_last,
    output logic               xfer_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] len_prog, cnt_prog;
    logic [CNT_W-1:0] new_len, new_cnt;

    // Programmed value is the written field plus one.
    assign new_len  = CNT_W'(len_field) + ONE;
    assign new_cnt  = CNT_W'(cnt_field) + ONE;
    // Current byte is the final one of its block / of the transfer.
    assign blk_last = (len_live == ONE);
    assign xfer_end = step && blk_last && (cnt_live == ONE);

    // Programming, reload and countdown of both counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_prog <= ONE;
            cnt_prog <= ONE;
            len_live <= ONE;
            cnt_live <= ONE;
        end else if (len_we || cnt_we) begin
            if (len_we) begin
                len_prog <= new_len;
                len_live <= new_len;
            end
            if (cnt_we) begin
                cnt_prog <= new_cnt;
                cnt_live <= new_cnt;
                len_live <= len_we ? new_len : len_prog;
            end
        end else if (step) begin
            if (blk_last) begin
                len_live <= len_prog;
                cnt_live <= (cnt_live == ONE) ? cnt_prog : cnt_live - ONE;
            end else begin
                len_live <= len_live - ONE;
            end
        end
    end
endmodule

// File: rtl/xfer_byte_packer.sv
// Packs card bytes into FIFO words on receive and splits FIFO words on transmit.
// Assumes the low byte travels first and that a block end closes the current word.
module xfer_byte_packer #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rx_acc,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_acc,
    input  logic              blk_last,
    input  logic [WORD_W-1:0] rd_word,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_word,
    output logic              rd_pop,
    output logic [BYTE_W-1:0] tx_byte
);
    logic              half;
    logic [BYTE_W-1:0] lo_q;
    logic              word_close;

    // A word closes on its second byte or on the last byte of a block.
    assign word_close = half || blk_last;
    assign wr_valid   = rx_acc && word_close;
    assign wr_word    = half ? {rx_byte, lo_q} : {{BYTE_W{1'b0}}, rx_byte};
    assign rd_pop     = tx_acc && word_close;
    assign tx_byte    = half ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];

    // Track which half of the word the next byte belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half <= 1'b0;
            lo_q <= '0;
        end else if (clr) begin
            half <= 1'b0;
        end else if (rx_acc || tx_acc) begin
            half <= !word_close;
            if (rx_acc) lo_q <= rx_byte;
        end
    end
endmodule

// File: rtl/blk_xfer_seq.sv
// Top of the block transfer sequencer: run control, flow gating and handshakes.
// Assumes the FIFO updates fifo_level on the clock edge after a push or pop.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter int AF_W  = LVL_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               len_we,
    input  logic [FIELD_W-1:0] len_field,
    input  logic               cnt_we,
    input  logic [FIELD_W-1:0] cnt_field,
    output logic [CNT_W-1:0]   len_live,
    output logic [CNT_W-1:0]   cnt_live,
    input  logic               start,
    input  logic               start_rx,
    output logic               busy,
    output logic               xfer_done,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic [AF_W-1:0]    af_level,
    output logic               fifo_wr_valid,
    output logic [WORD_W-1:0]  fifo_wr_word,
    output logic               fifo_rd_pop,
    input  logic [WORD_W-1:0]  fifo_rd_word,
    input  logic               card_rx_valid,
    output logic               card_rx_ready,
    input  logic [BYTE_W-1:0]  card_rx_data,
    output logic               card_tx_valid,
    input  logic               card_tx_ready,
    output logic [BYTE_W-1:0]  card_tx_data
);
    logic active, dir_rx;
    logic rx_acc, tx_acc, step;
    logic blk_last, xfer_end;
    logic above_af;

    // Flow gating: receive holds above threshold, transmit holds when empty.
    assign above_af      = fifo_level > LVL_W'(af_level);
    assign card_rx_ready = active && ctrl_en && dir_rx && !above_af;
    assign card_tx_valid = active && ctrl_en && !dir_rx && (fifo_level != '0);
    assign rx_acc        = card_rx_valid && card_rx_ready;
    assign tx_acc        = card_tx_valid && card_tx_ready;
    assign step          = rx_acc || tx_acc;
    assign busy          = active;

    // Run state: start, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            dir_rx    <= 1'b0;
            xfer_done <= 1'b0;
        end else if (!ctrl_en) begin
            active    <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            dir_rx    <= start_rx;
            xfer_done <= 1'b0;
        end else if (xfer_end) begin
            active    <= 1'b0;
            xfer_done <= 1'b1;
        end
    end

    xfer_len_blk_ctr #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n),
        .len_we(len_we), .len_field(len_field),
        .cnt_we(cnt_we), .cnt_field(cnt_field),
        .step(step),
        .len_live(len_live), .cnt_live(cnt_live),
        .blk_last(blk_last), .xfer_end(xfer_end)
    );

    xfer_byte_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) pack_i (
        .clk(clk), .rst_n(rst_n),
        .clr(start || !ctrl_en),
        .rx_acc(rx_acc), .rx_byte(card_rx_data),
        .tx_acc(tx_acc), .blk_last(blk_last),
        .rd_word(fifo_rd_word),
        .wr_valid(fifo_wr_valid), .wr_word(fifo_wr_word),
        .rd_pop(fifo_rd_pop), .tx_byte(card_tx_data)
    );
endmodule

// File: rtl/blk_xfer_seq_chk.sv
// Checker for the block transfer sequencer, attached by bind.
// Assumes the default widths of the top module.
module blk_xfer_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_en,
    input logic        busy,
    input logic        xfer_done,
    input logic [11:0] len_live,
    input logic [5:0]  fifo_level,
    input logic [4:0]  af_level,
    input logic        fifo_wr_valid,
    input logic        fifo_rd_pop,
    input logic        card_rx_ready,
    input logic        card_tx_valid
);
    assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (fifo_level <= {1'b0, af_level}));
    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> (fifo_level != 6'd0));
    assert_push_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_valid |-> busy);
    assert_pop_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_pop |-> busy);
    assert_one_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_wr_valid && fifo_rd_pop));
    assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        len_live != 12'd0);
    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(busy));
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !busy && !$rose(xfer_done));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .busy(busy),
    .xfer_done(xfer_done), .len_live(len_live), .fifo_level(fifo_level),
    .af_level(af_level), .fifo_wr_valid(fifo_wr_valid),
    .fifo_rd_pop(fifo_rd_pop), .card_rx_ready(card_rx_ready),
    .card_tx_valid(card_tx_valid)
);

// File: tb/blk_xfer_seq_tb.sv
// Scoreboard bench: driver tasks queue expected words/bytes, a monitor compares them.
module blk_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_en = 1'b0;
    logic len_we = 1'b0, cnt_we = 1'b0;
    logic [10:0] len_field = '0, cnt_field = '0;
    logic [11:0] len_live, cnt_live;
    logic start = 1'b0, start_rx = 1'b0;
    logic busy, xfer_done;
    logic [5:0] fifo_level;
    logic [4:0] af_level = 5'd31;
    logic fifo_wr_valid, fifo_rd_pop;
    logic [15:0] fifo_wr_word, fifo_rd_word;
    logic card_rx_valid, card_rx_ready;
    logic [7:0] card_rx_data, card_tx_data;
    logic card_tx_valid, card_tx_ready;

    int n_vec = 0, n_fail = 0, m_vec = 0, m_fail = 0;
    logic [15:0] expw[$];
    logic [7:0]  expb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .len_we(len_we), .len_field(len_field),
        .cnt_we(cnt_we), .cnt_field(cnt_field),
        .len_live(len_live), .cnt_live(cnt_live),
        .start(start), .start_rx(start_rx),
        .busy(busy), .xfer_done(xfer_done),
        .fifo_level(fifo_level), .af_level(af_level),
        .fifo_wr_valid(fifo_wr_valid), .fifo_wr_word(fifo_wr_word),
        .fifo_rd_pop(fifo_rd_pop), .fifo_rd_word(fifo_rd_word),
        .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
        .card_rx_data(card_rx_data),
        .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
        .card_tx_data(card_tx_data)
    );

    function automatic logic [7:0] bf(int i);
        return 8'(i * 37 + 11);
    endfunction

    // FIFO model: design pushes on receive, host pushes on transmit.
    logic [15:0] fmem [0:63];
    logic [6:0] wp = '0, rp = '0;
    logic h_push = 1'b0, h_drain = 1'b0, h_pop;
    logic [15:0] h_word = '0;
    assign fifo_level   = 6'(wp - rp);
    assign fifo_rd_word = fmem[rp[5:0]];
    assign h_pop = h_drain && (fifo_level != 6'd0);
    always @(posedge clk) begin
        if (fifo_wr_valid) begin
            fmem[wp[5:0]] <= fifo_wr_word;
            wp <= wp + 7'd1;
        end else if (h_push) begin
            fmem[wp[5:0]] <= h_word;
            wp <= wp + 7'd1;
        end
        if (fifo_rd_pop || h_pop) rp <= rp + 7'd1;
    end

    // Card model: byte source with a limit, sink with optional stutter.
    int src_idx = 0;
    int src_limit = 0;
    logic tog = 1'b0, tx_throttle = 1'b0;
    assign card_rx_valid = src_idx < src_limit;
    assign card_rx_data  = bf(src_idx);
    assign card_tx_ready = tx_throttle ? tog : 1'b1;
    always @(posedge clk) begin
        tog <= ~tog;
        if (card_rx_valid && card_rx_ready) src_idx <= src_idx + 1;
    end

    // Monitor: compare produced words and bytes against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr_valid) begin
                m_vec++;
                if (expw.size() == 0) begin
                    m_fail++;
                    $display("FAIL R3 unexpected word actual=%h expected=none", fifo_wr_word);
                end else begin
                    logic [15:0] e;
                    e = expw.pop_front();
                    if (fifo_wr_word !== e) begin
                        m_fail++;
                        $display("FAIL R3 rx word actual=%h expected=%h", fifo_wr_word, e);
                    end
                end
            end
            if (card_tx_valid && card_tx_ready) begin
                m_vec++;
                if (expb.size() == 0) begin
                    m_fail++;
                    $display("FAIL R5 unexpected byte actual=%h expected=none", card_tx_data);
                end else begin
                    logic [7:0] eb;
                    eb = expb.pop_front();
                    if (card_tx_data !== eb) begin
                        m_fail++;
                        $display("FAIL R5 tx byte actual=%h expected=%h", card_tx_data, eb);
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic waitn(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(int lf, int cf);
        len_we = 1'b1; len_field = 11'(lf); tick(); len_we = 1'b0;
        cnt_we = 1'b1; cnt_field = 11'(cf); tick(); cnt_we = 1'b0;
    endtask

    task automatic go(logic rx);
        start = 1'b1; start_rx = rx; tick(); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !xfer_done; i++) tick();
    endtask

    // Driver for receive: expected packed words for len bytes x cnt blocks.
    task automatic rx_plan(int base, int len, int cnt);
        int k = 0;
        for (int b = 0; b < cnt; b++) begin
            for (int i = 0; i < len; i += 2) begin
                if (i + 1 < len) begin
                    expw.push_back({bf(base + k + 1), bf(base + k)});
                    k += 2;
                end else begin
                    expw.push_back({8'h00, bf(base + k)});
                    k += 1;
                end
            end
        end
    endtask

    // Driver for transmit: host words into FIFO, expected bytes to scoreboard.
    task automatic tx_load(int seed, int len, int cnt);
        int k = 0;
        for (int b = 0; b < cnt; b++) begin
            for (int i = 0; i < len; i += 2) begin
                logic [15:0] w;
                if (i + 1 < len) begin
                    w = {bf(seed + k + 1), bf(seed + k)};
                    expb.push_back(bf(seed + k));
                    expb.push_back(bf(seed + k + 1));
                    k += 2;
                end else begin
                    w = {8'hEE, bf(seed + k)};
                    expb.push_back(bf(seed + k));
                    k += 1;
                end
                while (fifo_level > 6'd56) tick();
                h_word = w; h_push = 1'b1; tick(); h_push = 1'b0;
            end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec + m_vec, n_fail + m_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int base;
        waitn(3);
        rst_n = 1'b1; ctrl_en = 1'b1;
        tick();
        // R1: reset state
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", xfer_done, 0);
        chk("R1 len_live after reset", len_live, 1);
        chk("R1 cnt_live after reset", cnt_live, 1);

        // R1 programming: field plus one
        prog(4, 2);
        chk("R1 len programmed", len_live, 5);
        chk("R1 cnt programmed", cnt_live, 3);

        // R3/R6/R8: receive odd length, partial then full
        h_drain = 1'b1; af_level = 5'd31;
        base = src_idx;
        rx_plan(base, 5, 3);
        src_limit = base + 7;
        go(1'b1);
        chk("R10 busy after start", busy, 1);
        waitn(20);
        chk("R8 len_live mid transfer", len_live, 3);
        chk("R6 cnt_live after first block", cnt_live, 2);
        chk("R4 busy while starved", busy, 1);
        src_limit = base + 20;
        wait_done();
        waitn(5);
        chk("R7 done set", xfer_done, 1);
        chk("R7 busy cleared", busy, 0);
        chk("R7 len reloaded", len_live, 5);
        chk("R7 cnt reloaded", cnt_live, 3);
        chk("R7 no byte after end", src_idx, base + 15);
        chk("R3 all words produced", expw.size(), 0);
        src_limit = src_idx;

        // R2/R9/R10: restart, rewrite count mid transfer, then abort
        base = src_idx;
        rx_plan(base, 5, 1);
        expw.push_back({bf(base + 6), bf(base + 5)});
        src_limit = base + 7;
        go(1'b1);
        chk("R10 done cleared by start", xfer_done, 0);
        waitn(20);
        chk("R8 len_live partial", len_live, 3);
        cnt_we = 1'b1; cnt_field = 11'd1; tick(); cnt_we = 1'b0;
        chk("R2 len reloaded by count write", len_live, 5);
        chk("R2 cnt reloaded by count write", cnt_live, 2);
        ctrl_en = 1'b0; tick();
        chk("R9 busy cleared by abort", busy, 0);
        chk("R9 done not set by abort", xfer_done, 0);
        go(1'b1);
        chk("R9 start ignored while disabled", busy, 0);
        ctrl_en = 1'b1; tick();
        chk("R3 words before abort", expw.size(), 0);
        src_limit = src_idx;

        // R4: receive stall at threshold
        waitn(5);
        h_drain = 1'b0; af_level = 5'd3;
        prog(19, 0);
        base = src_idx;
        rx_plan(base, 20, 1);
        src_limit = base + 20;
        go(1'b1);
        waitn(20);
        chk("R4 fifo stops above threshold", fifo_level, 4);
        chk("R4 rx not ready when above", card_rx_ready, 0);
        chk("R8 len_live at stall", len_live, 12);
        h_drain = 1'b1;
        wait_done();
        chk("R4 resumes and finishes", xfer_done, 1);
        waitn(5);
        af_level = 5'd31;
        h_drain = 1'b0;

        // R4/R5: transmit odd length, starts with empty FIFO
        prog(2, 1);
        go(1'b0);
        waitn(3);
        chk("R4 tx not valid when empty", card_tx_valid, 0);
        chk("R4 tx still busy when empty", busy, 1);
        chk("R10 rx not ready in transmit", card_rx_ready, 0);
        tx_load(100, 3, 2);
        wait_done();
        waitn(2);
        chk("R7 tx done", xfer_done, 1);
        chk("R5 odd word popped", fifo_level, 0);
        chk("R5 all bytes sent", expb.size(), 0);

        // R5/R6: transmit even length with stuttering card
        tx_throttle = 1'b1;
        prog(5, 2);
        go(1'b0);
        tx_load(200, 6, 3);
        wait_done();
        waitn(2);
        chk("R6 tx stutter done", xfer_done, 1);
        chk("R6 cnt reloaded after tx", cnt_live, 3);
        chk("R5 stutter bytes sent", expb.size(), 0);
        chk("R5 fifo drained", fifo_level, 0);
        tx_throttle = 1'b0;

        waitn(3);
        summary();
    end
endmodule